// File: doc/BRIEF.md
# Soft-Start Reference Staircase Sequencer

This block produces the rising reference code that a switching regulator's error amplifier follows during start-up. A digital-to-analog converter outside the block turns the code into a voltage. The code climbs from zero to full scale one step at a time, and each step is held for a fixed count of switching periods. The time base is the oscillator's once-per-period strobe, not the block clock. As a result, the total start-up time scales inversely with the switching frequency. With the default widths there are 64 steps of 32 strobes each, which is 2048 periods in total, or 8 ms at 250 kHz.

The ramp runs only while the enable input is high and neither the undervoltage nor the over-temperature fault input is high. If any of those conditions is lost, the whole sequence is cancelled. The code returns to zero and the step prescaler is cleared, so the ramp later restarts from the very beginning. The block also provides a gate permission output for the power-switch driver. This output is low whenever the code sits at zero or the ramp is not allowed to run.

Top module: `softstart_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `ref_code` is 0, `ramp_done` is 0 and `switch_allow` is 0.
- R2: While running, `ref_code` (plain unsigned binary) increases by exactly one on the clock edge that samples the 32nd `sw_strobe` of a step.
- R3: Clock cycles with `sw_strobe` low change neither `ref_code` nor `ramp_done`.
- R4: While running, `ref_code` never decreases and never moves by more than one per cycle.
- R5: `ramp_done` rises on the edge that samples the 2048th strobe counted from a restart. It then stays high, with `ref_code` held, for as long as the block keeps running.
- R6: A cycle with `enable` low clears `ref_code`, `ramp_done` and the step prescaler at the next edge, so the next step needs 32 fresh strobes.
- R7: A cycle with `uvlo_fault` high has the same clearing effect as R6.
- R8: A cycle with `thermal_fault` high has the same clearing effect as R6, including after the ramp has finished.
- R9: `switch_allow` is 1 exactly when `enable` is high, both fault inputs are low and `ref_code` is nonzero. It follows the inputs in the same cycle.
- R10: `ramp_done` is 1 only while `ref_code` equals full scale, 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_strobe | input | 1 | One-cycle pulse per switching period |
| enable | input | 1 | Regulator enable, high to run |
| uvlo_fault | input | 1 | Input undervoltage condition, high = fault |
| thermal_fault | input | 1 | Over-temperature shutdown, high = fault |
| ref_code | output | 6 | Reference step code, 0 to 63 |
| ramp_done | output | 1 | Ramp finished, code held at full scale |
| switch_allow | output | 1 | Permission for the power switch to turn on |

## Verification
The assertions take two things for granted about the inputs. The first is that all inputs are synchronous to `clk` and change once per cycle. The second is that `sw_strobe` is at most one cycle wide per switching period, so each high cycle is counted as exactly one period. The stimulus changes every input on the falling edge. It issues each strobe as a single-cycle pulse, and sometimes separates strobes by idle cycles to imitate a switching period longer than the clock. The enable and fault inputs are dropped for whole cycles only. These drops are placed mid-step, mid-ramp and after completion, so that the restart paths are exercised from each phase.

// File: rtl/ss_pkg.sv
package ss_pkg;

    localparam int SS_PRESC_W = 5;
    localparam int SS_CODE_W  = 6;

    // Conditions that gate the ramp, gathered in one place
    typedef struct packed {
        logic enable;
        logic uvlo;
        logic thermal;
    } ss_gate_t;

    typedef enum logic [1:0] {
        SS_HALT = 2'd0,
        SS_RISE = 2'd1,
        SS_FULL = 2'd2
    } ss_phase_t;

    function automatic logic ss_may_run(input ss_gate_t g);
        return g.enable && !g.uvlo && !g.thermal;
    endfunction

endpackage

// File: rtl/ss_qualify.sv
module ss_qualify
    import ss_pkg::*;
(
    input  ss_gate_t gate_in,
    output logic     run
);
    always_comb begin
        run = ss_may_run(gate_in);
    end
endmodule

// File: rtl/ss_prescaler.sv
module ss_prescaler #(
    parameter int PRESC_W = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic strobe,
    output logic tick
);
    logic [PRESC_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (strobe) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Last strobe of a step: the counter is about to wrap
    assign tick = run && strobe && (&cnt_q);
endmodule

// File: rtl/ss_stepper.sv
module ss_stepper
    import ss_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              tick,
    output logic [CODE_W-1:0] code,
    output ss_phase_t         phase
);
    localparam logic [CODE_W-1:0] TOP = {CODE_W{1'b1}};

    logic [CODE_W-1:0] code_q;
    ss_phase_t         phase_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            code_q  <= '0;
            phase_q <= SS_HALT;
        end else begin
            unique case (phase_q)
                SS_HALT: begin
                    phase_q <= SS_RISE;
                    if (tick) code_q <= code_q + 1'b1;
                end
                SS_RISE: begin
                    if (tick) begin
                        if (code_q == TOP) phase_q <= SS_FULL;
                        else               code_q  <= code_q + 1'b1;
                    end
                end
                SS_FULL: begin
                    code_q <= TOP;
                end
                default: phase_q <= SS_HALT;
            endcase
        end
    end

    assign code  = code_q;
    assign phase = phase_q;
endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
    import ss_pkg::*;
#(
    parameter int PRESC_W = SS_PRESC_W,
    parameter int CODE_W  = SS_CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_strobe,
    input  logic              enable,
    input  logic              uvlo_fault,
    input  logic              thermal_fault,
    output logic [CODE_W-1:0] ref_code,
    output logic              ramp_done,
    output logic              switch_allow
);
    ss_gate_t  gate;
    logic      run;
    logic      tick;
    ss_phase_t phase;

    assign gate = '{enable: enable, uvlo: uvlo_fault, thermal: thermal_fault};

    ss_qualify u_qual (
        .gate_in (gate),
        .run     (run)
    );

    ss_prescaler #(.PRESC_W(PRESC_W)) u_presc (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .strobe (sw_strobe),
        .tick   (tick)
    );

    ss_stepper #(.CODE_W(CODE_W)) u_step (
        .clk   (clk),
        .rst   (rst),
        .run   (run),
        .tick  (tick),
        .code  (ref_code),
        .phase (phase)
    );

    assign ramp_done    = (phase == SS_FULL);
    assign switch_allow = run && (ref_code != '0);
endmodule

// File: rtl/softstart_seq_chk.sv
module softstart_seq_chk #(
    parameter int CODE_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              sw_strobe,
    input logic              enable,
    input logic              uvlo_fault,
    input logic              thermal_fault,
    input logic [CODE_W-1:0] ref_code,
    input logic              ramp_done,
    input logic              switch_allow
);
    localparam logic [CODE_W-1:0] FULL = {CODE_W{1'b1}};

    logic go;
    assign go = enable && !uvlo_fault && !thermal_fault;

    assert_monotonic_R4: assert property (@(posedge clk) disable iff (rst)
        $past(go) |-> (ref_code == $past(ref_code) ||
                       ref_code == CODE_W'($past(ref_code) + 1'b1)));

    assert_idle_stable_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(go) && !$past(sw_strobe)) |-> ($stable(ref_code) && $stable(ramp_done)));

    // covers R6, R7 and R8: any lost condition clears the ramp
    assert_restart_clear_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(go) |-> (ref_code == '0 && !ramp_done));

    assert_done_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(go) && $past(ramp_done)) |-> (ramp_done && ref_code == FULL));

    assert_done_full_R10: assert property (@(posedge clk) disable iff (rst)
        ramp_done |-> ref_code == FULL);

    assert_gate_R9: assert property (@(posedge clk) disable iff (rst)
        switch_allow == (go && ref_code != '0));
endmodule

bind softstart_seq softstart_seq_chk #(.CODE_W(CODE_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .sw_strobe     (sw_strobe),
    .enable        (enable),
    .uvlo_fault    (uvlo_fault),
    .thermal_fault (thermal_fault),
    .ref_code      (ref_code),
    .ramp_done     (ramp_done),
    .switch_allow  (switch_allow)
);

// File: tb/softstart_seq_bench.sv
module softstart_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int STEP_LEN   = 32;
    localparam int TOP_CODE   = 63;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sw_strobe = 1'b0;
    logic       enable = 1'b0;
    logic       uvlo_fault = 1'b0;
    logic       thermal_fault = 1'b0;
    logic [5:0] ref_code;
    logic       ramp_done;
    logic       switch_allow;

    typedef struct {
        int    code;
        bit    done;
        bit    sw;
        string tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int m_pre = 0;
    int m_code = 0;
    bit m_done = 0;

    softstart_seq u_softstart_seq (
        .clk           (clk),
        .rst           (rst),
        .sw_strobe     (sw_strobe),
        .enable        (enable),
        .uvlo_fault    (uvlo_fault),
        .thermal_fault (thermal_fault),
        .ref_code      (ref_code),
        .ramp_done     (ramp_done),
        .switch_allow  (switch_allow)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Driver: applies one cycle of inputs and queues the outcome after the edge
    task automatic cyc(input bit e, input bit u, input bit t, input bit s, input string tag);
        exp_t it;
        bit   go;
        @(negedge clk);
        enable = e; uvlo_fault = u; thermal_fault = t; sw_strobe = s;
        go = e && !u && !t;
        if (!go) begin
            m_pre = 0; m_code = 0; m_done = 0;
        end else if (s) begin
            if (m_pre == STEP_LEN - 1) begin
                m_pre = 0;
                if (m_code == TOP_CODE) m_done = 1;
                else m_code++;
            end else begin
                m_pre++;
            end
        end
        it.code = m_code;
        it.done = m_done;
        it.sw   = go && (m_code != 0);
        it.tag  = tag;
        q.push_back(it);
    endtask

    task automatic strobes(input int n, input int gap, input string tag);
        for (int i = 0; i < n; i++) begin
            cyc(1, 0, 0, 1, tag);
            for (int j = 0; j < gap; j++) cyc(1, 0, 0, 0, tag);
        end
    endtask

    // Monitor: compares each queued item just after the edge it belongs to
    always begin : monitor
        exp_t it;
        @(posedge clk);
        #3;
        if (q.size() > 0) begin
            it = q.pop_front();
            chk(it.tag, "ref_code", int'(ref_code), it.code);
            chk(it.tag, "ramp_done", int'(ramp_done), int'(it.done));
            chk(it.tag, "switch_allow", int'(switch_allow), int'(it.sw));
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog actual hung expected finish");
        summary();
    end

    initial begin : stimulus
        repeat (4) @(posedge clk);
        #1;
        chk("R1", "ref_code in reset", int'(ref_code), 0);
        chk("R1", "ramp_done in reset", int'(ramp_done), 0);
        chk("R1", "switch_allow in reset", int'(switch_allow), 0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1", "switch_allow after reset", int'(switch_allow), 0);

        repeat (3) cyc(0, 0, 0, 1, "R9");
        strobes(STEP_LEN - 1, 0, "R2");
        strobes(1, 0, "R2");
        @(posedge clk); #4;
        chk("R2", "code after first step", int'(ref_code), 1);
        repeat (40) cyc(1, 0, 0, 0, "R3");
        strobes(100, 2, "R4");

        cyc(0, 0, 0, 1, "R6");
        strobes(STEP_LEN - 1, 0, "R6");
        @(posedge clk); #4;
        chk("R6", "code one strobe short of step", int'(ref_code), 0);
        strobes(10, 0, "R6");

        strobes(5, 0, "R7");
        cyc(1, 1, 0, 1, "R7");
        strobes(40, 1, "R7");
        cyc(1, 0, 1, 0, "R8");
        strobes(70, 0, "R8");

        cyc(0, 0, 0, 0, "R5");
        strobes(64 * STEP_LEN - 1, 0, "R5");
        @(posedge clk); #4;
        chk("R10", "done before last strobe", int'(ramp_done), 0);
        chk("R10", "code at full scale", int'(ref_code), TOP_CODE);
        strobes(1, 0, "R5");
        @(posedge clk); #4;
        chk("R5", "done after 2048 strobes", int'(ramp_done), 1);
        strobes(50, 1, "R5");
        repeat (20) cyc(1, 0, 0, 0, "R10");
        cyc(1, 0, 1, 1, "R8");
        @(posedge clk); #4;
        chk("R8", "done cleared by thermal", int'(ramp_done), 0);
        strobes(40, 0, "R9");
        cyc(1, 1, 0, 0, "R9");
        cyc(1, 0, 0, 0, "R9");

        repeat (3) @(posedge clk);
        #5;
        summary();
    end
endmodule